// File: doc/BRIEF.md
# Shadow Stack Far Call Frame Pusher

This sequencer builds the shadow-stack record that a far procedure call leaves behind. It is started once per call with a snapshot of the caller's state: the current shadow pointer, the caller's code selector, code base and instruction offset, the caller's privilege level, and the pointer held for the target privilege level. It captures that snapshot on the start cycle, so the inputs may change while it runs. It then issues a short series of memory operations on a single request/acknowledge port, one at a time.

Two call kinds are handled. On a call that stays at the same privilege level, the block aligns the pointer downward to 8 bytes and writes a 4-byte zero pad just below the unaligned pointer. It then pushes three 8-byte records below the aligned pointer: the caller's selector, the caller's linear instruction address, and the pointer the call started from. On a call into a more privileged level, the block switches to the pointer supplied for that level and validates it. It claims the supervisor token at that address with a compare-exchange on its busy bit. It pushes the three records below the token only when the caller did not run at user level. When the caller did run at user level, it instead hands back the caller's pointer for saving, sign-adjusted in long mode.

A failed rule or a lost token claim ends the run with a one-cycle fault pulse. No further memory operation follows, and no pointer update is asserted.

Top module: `ssfp_frame_pusher`

## Requirements
- R1: On a same-level call, the first memory operation is a 4-byte write of zero (`mem_size8`=0, `mem_xchg`=0) at the starting pointer minus 4.
- R2: On a same-level call, let A be the starting pointer with bits 2:0 cleared. After the pad come three 8-byte writes: the zero-extended selector at A-8, then the code base plus offset at A-16, then the starting pointer at A-24.
- R3: A same-level call ends with `done` and `ssp_wr` high for one cycle and `ssp_out` equal to A-24.
- R4: On a same-level call into a non-64-bit target (`tgt_long`=0), a starting pointer with any of bits 63:32 set produces `fault` two cycles after the start edge. No memory operation is issued, and `ssp_wr` and `usr_wr` stay low.
- R5: On a more-privilege call, a target-level pointer whose bits 2:0 are not zero faults two cycles after the start edge, with no memory operation.
- R6: On a more-privilege call, the target-level pointer P must satisfy P[63:5] == (P-24)[63:5]. Otherwise the call faults two cycles after the start edge, with no memory operation.
- R7: On a more-privilege call, the first memory operation is a compare-exchange (`mem_xchg`=1, 8 bytes) at P, with compare value P with bit 0 clear and write value P with bit 0 set. If the returned `mem_rdata` differs from the compare value, the call faults and issues no further operation.
- R8: After a successful claim, a caller level other than 3 pushes the selector at P-8, the linear address at P-16 and the starting pointer at P-24, and ends with `ssp_out` = P-24. A caller level of 3 pushes nothing and ends with `ssp_out` = P.
- R9: A more-privilege call from caller level 3 ends with `usr_wr` high alongside `done`. In long mode, `usr_ssp` carries the starting pointer with bits 63:48 copied from bit 47; otherwise it carries the starting pointer unchanged.
- R10: A request stays asserted with stable address, data and kind until `mem_ack`, and only one request is outstanding at a time.
- R11: After reset and between calls `busy`, `mem_req`, `done` and `fault` are low. `done` and `fault` are never high together. A `start` arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a call sequence (sampled when idle) |
| more_priv | input | 1 | 1 = call into a more privileged level |
| tgt_long | input | 1 | Target runs in 64-bit mode |
| long_active | input | 1 | Long mode active |
| caller_pl | input | 2 | Caller privilege level |
| cur_ssp | input | 64 | Current shadow pointer |
| new_ssp | input | 64 | Shadow pointer of the target level |
| old_sel | input | 16 | Caller code selector |
| cs_base | input | 64 | Caller code segment base |
| old_ip | input | 64 | Caller instruction offset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle general-protection pulse |
| ssp_wr | output | 1 | Update shadow pointer with `ssp_out` |
| ssp_out | output | 64 | New shadow pointer |
| usr_wr | output | 1 | Save `usr_ssp` as the user-level pointer |
| usr_ssp | output | 64 | User-level pointer to save |
| mem_req | output | 1 | Memory request valid |
| mem_xchg | output | 1 | 1 = compare-exchange, 0 = write |
| mem_size8 | output | 1 | 1 = 8-byte, 0 = 4-byte access |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write / exchange data |
| mem_cmp | output | 64 | Compare value for exchange |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | 64 | Old memory value for exchange |

## Verification
A rule fault (R4, R5, R6) is due exactly two edges after the start edge: one edge moves the sequencer into evaluation, the next into the fault state. The bench counts falling edges from the start pulse and samples there. Memory results have no fixed latency, because the responder waits zero to three random cycles per request. The bench therefore logs each request at the falling edge on which it acknowledges it. It compares the log entry by entry with the expected operation list once `done` or `fault` is seen, and compares `ssp_out` and the user pointer in that same cycle. One falling edge later it checks that the block is idle again.

// File: rtl/ssfp_pkg.sv
package ssfp_pkg;
   localparam int REC_BYTES  = 8;
   localparam int REC_LG     = 3;
   localparam int FRAME_RECS = 3;
   localparam int REGION_LG  = 5;
   localparam int PAD_BYTES  = 4;
   localparam int LOW_SPAN   = 32;
   localparam logic [1:0] USER_PL = 2'd3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EVAL,
      ST_PAD,
      ST_TOKEN,
      ST_REC_SEL,
      ST_REC_LIP,
      ST_REC_PREV,
      ST_FIN,
      ST_FLT
   } ssfp_state_e;
endpackage

// File: rtl/ssfp_rules.sv
module ssfp_rules
   import ssfp_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              tgt_long,
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] newp,
   output logic              hi_flt,
   output logic              align_flt,
   output logic              region_flt
);
   localparam int FRAME_SPAN = FRAME_RECS * REC_BYTES;

   logic [ADDR_W-1:0] frame_low;

   generate
      if (ADDR_W > LOW_SPAN) begin : g_hi
         always_comb hi_flt = !tgt_long && (|cur[ADDR_W-1:LOW_SPAN]);
      end else begin : g_nohi
         always_comb hi_flt = 1'b0;
      end
   endgenerate

   always_comb begin
      frame_low  = newp - ADDR_W'(FRAME_SPAN);
      align_flt  = |newp[REC_LG-1:0];
      region_flt = newp[ADDR_W-1:REGION_LG] != frame_low[ADDR_W-1:REGION_LG];
   end
endmodule

// File: rtl/ssfp_sadj.sv
module ssfp_sadj #(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48
) (
   input  logic              long_active,
   input  logic [ADDR_W-1:0] raw,
   output logic [ADDR_W-1:0] adj
);
   generate
      if (VA_BITS < ADDR_W) begin : g_ext
         always_comb
            adj = long_active ? {{(ADDR_W-VA_BITS){raw[VA_BITS-1]}}, raw[VA_BITS-1:0]}
                              : raw;
      end else begin : g_pass
         always_comb adj = raw;
      end
   endgenerate
endmodule

// File: rtl/ssfp_seq.sv
module ssfp_seq
   import ssfp_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SEL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              more,
   input  logic [1:0]        pl,
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] newp,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] lip,
   input  logic              hi_flt,
   input  logic              align_flt,
   input  logic              region_flt,
   output logic              launch,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [ADDR_W-1:0] ptr_q,
   output logic              mem_req,
   output logic              mem_xchg,
   output logic              mem_size8,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] mem_cmp,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(REC_BYTES);
   localparam logic [ADDR_W-1:0] PAD_OFF  = ADDR_W'(PAD_BYTES);
   localparam logic [ADDR_W-1:0] ALN_MASK = ~ADDR_W'(REC_BYTES - 1);

   ssfp_state_e       state;
   logic [ADDR_W-1:0] tok_free;

   always_comb begin
      tok_free = {ptr_q[ADDR_W-1:1], 1'b0};
      launch   = start && (state == ST_IDLE);
      busy     = state != ST_IDLE;
      done     = state == ST_FIN;
      fault    = state == ST_FLT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ptr_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) state <= ST_EVAL;
            ST_EVAL: begin
               if (more) begin
                  if (align_flt || region_flt) state <= ST_FLT;
                  else begin
                     ptr_q <= newp;
                     state <= ST_TOKEN;
                  end
               end else begin
                  if (hi_flt) state <= ST_FLT;
                  else begin
                     ptr_q <= cur & ALN_MASK;
                     state <= ST_PAD;
                  end
               end
            end
            ST_PAD: if (mem_ack) state <= ST_REC_SEL;
            ST_TOKEN: begin
               if (mem_ack) begin
                  if (mem_rdata != tok_free) state <= ST_FLT;
                  else if (pl != USER_PL)    state <= ST_REC_SEL;
                  else                       state <= ST_FIN;
               end
            end
            ST_REC_SEL: begin
               if (mem_ack) begin
                  ptr_q <= ptr_q - STEP;
                  state <= ST_REC_LIP;
               end
            end
            ST_REC_LIP: begin
               if (mem_ack) begin
                  ptr_q <= ptr_q - STEP;
                  state <= ST_REC_PREV;
               end
            end
            ST_REC_PREV: begin
               if (mem_ack) begin
                  ptr_q <= ptr_q - STEP;
                  state <= ST_FIN;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            ST_FLT:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_xchg  = 1'b0;
      mem_size8 = 1'b1;
      mem_addr  = '0;
      mem_wdata = '0;
      mem_cmp   = '0;
      unique case (state)
         ST_PAD: begin
            mem_req   = 1'b1;
            mem_size8 = 1'b0;
            mem_addr  = cur - PAD_OFF;
         end
         ST_TOKEN: begin
            mem_req   = 1'b1;
            mem_xchg  = 1'b1;
            mem_addr  = ptr_q;
            mem_cmp   = tok_free;
            mem_wdata = {ptr_q[ADDR_W-1:1], 1'b1};
         end
         ST_REC_SEL: begin
            mem_req               = 1'b1;
            mem_addr              = ptr_q - STEP;
            mem_wdata[SEL_W-1:0]  = sel;
         end
         ST_REC_LIP: begin
            mem_req   = 1'b1;
            mem_addr  = ptr_q - STEP;
            mem_wdata = lip;
         end
         ST_REC_PREV: begin
            mem_req   = 1'b1;
            mem_addr  = ptr_q - STEP;
            mem_wdata = cur;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ssfp_frame_pusher.sv
module ssfp_frame_pusher
   import ssfp_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48,
   parameter int SEL_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              more_priv,
   input  logic              tgt_long,
   input  logic              long_active,
   input  logic [1:0]        caller_pl,
   input  logic [ADDR_W-1:0] cur_ssp,
   input  logic [ADDR_W-1:0] new_ssp,
   input  logic [SEL_W-1:0]  old_sel,
   input  logic [ADDR_W-1:0] cs_base,
   input  logic [ADDR_W-1:0] old_ip,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic              ssp_wr,
   output logic [ADDR_W-1:0] ssp_out,
   output logic              usr_wr,
   output logic [ADDR_W-1:0] usr_ssp,
   output logic              mem_req,
   output logic              mem_xchg,
   output logic              mem_size8,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] mem_cmp,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   generate
      if (ADDR_W <= LOW_SPAN) begin : g_bad_addr
         $error("ssfp_frame_pusher: ADDR_W must exceed the low span");
      end
      if (VA_BITS < 2 || VA_BITS > ADDR_W) begin : g_bad_va
         $error("ssfp_frame_pusher: VA_BITS out of range");
      end
      if (SEL_W < 1 || SEL_W > ADDR_W) begin : g_bad_sel
         $error("ssfp_frame_pusher: SEL_W out of range");
      end
   endgenerate

   logic              launch;
   logic              l_more, l_tgt, l_lma;
   logic [1:0]        l_pl;
   logic [ADDR_W-1:0] l_cur, l_new, l_lip;
   logic [SEL_W-1:0]  l_sel;
   logic              hi_flt, align_flt, region_flt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_more <= 1'b0;
         l_tgt  <= 1'b0;
         l_lma  <= 1'b0;
         l_pl   <= '0;
         l_cur  <= '0;
         l_new  <= '0;
         l_lip  <= '0;
         l_sel  <= '0;
      end else if (launch) begin
         l_more <= more_priv;
         l_tgt  <= tgt_long;
         l_lma  <= long_active;
         l_pl   <= caller_pl;
         l_cur  <= cur_ssp;
         l_new  <= new_ssp;
         l_lip  <= cs_base + old_ip;
         l_sel  <= old_sel;
      end
   end

   ssfp_rules #(.ADDR_W(ADDR_W)) u_rules (
      .tgt_long   (l_tgt),
      .cur        (l_cur),
      .newp       (l_new),
      .hi_flt     (hi_flt),
      .align_flt  (align_flt),
      .region_flt (region_flt)
   );

   ssfp_sadj #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_sadj (
      .long_active (l_lma),
      .raw         (l_cur),
      .adj         (usr_ssp)
   );

   ssfp_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .more       (l_more),
      .pl         (l_pl),
      .cur        (l_cur),
      .newp       (l_new),
      .sel        (l_sel),
      .lip        (l_lip),
      .hi_flt     (hi_flt),
      .align_flt  (align_flt),
      .region_flt (region_flt),
      .launch     (launch),
      .busy       (busy),
      .done       (done),
      .fault      (fault),
      .ptr_q      (ssp_out),
      .mem_req    (mem_req),
      .mem_xchg   (mem_xchg),
      .mem_size8  (mem_size8),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_cmp    (mem_cmp),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata)
   );

   always_comb begin
      ssp_wr = done;
      usr_wr = done && l_more && (l_pl == USER_PL);
   end
endmodule

// File: rtl/ssfp_frame_pusher_chk.sv
module ssfp_frame_pusher_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              fault,
   input logic              ssp_wr,
   input logic              usr_wr,
   input logic              mem_req,
   input logic              mem_xchg,
   input logic              mem_size8,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic [ADDR_W-1:0] mem_cmp,
   input logic              mem_ack
);
   // R1
   pad_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_size8) |-> (!mem_xchg && mem_wdata == '0));

   // R2
   rec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size8 && !mem_xchg) |-> (mem_addr[2:0] == 3'd0));

   // R4
   fault_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!ssp_wr && !usr_wr));

   // R7
   token_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_xchg) |-> (mem_size8 && !mem_cmp[0] && mem_addr == mem_cmp
                                 && mem_wdata == {mem_cmp[ADDR_W-1:1], 1'b1}));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                 && $stable(mem_xchg) && $stable(mem_size8)));

   // R10
   req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (!mem_req || mem_addr != $past(mem_addr)));

   // R11
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done && !fault));
endmodule

bind ssfp_frame_pusher ssfp_frame_pusher_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .fault     (fault),
   .ssp_wr    (ssp_wr),
   .usr_wr    (usr_wr),
   .mem_req   (mem_req),
   .mem_xchg  (mem_xchg),
   .mem_size8 (mem_size8),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_cmp   (mem_cmp),
   .mem_ack   (mem_ack)
);

// File: tb/tb_ssfp_frame_pusher.sv
module tb_ssfp_frame_pusher;
   localparam int CLK_PERIOD = 10;
   localparam int MAXOPS     = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, more_priv = 1'b0, tgt_long = 1'b0, long_active = 1'b0;
   logic [1:0]  caller_pl = '0;
   logic [63:0] cur_ssp = '0, new_ssp = '0, cs_base = '0, old_ip = '0;
   logic [15:0] old_sel = '0;
   logic        busy, done, fault, ssp_wr, usr_wr;
   logic [63:0] ssp_out, usr_ssp;
   logic        mem_req, mem_xchg, mem_size8;
   logic [63:0] mem_addr, mem_wdata, mem_cmp;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   logic [63:0] tok_val = '0;
   int          log_n = 0;
   logic [63:0] log_addr [MAXOPS], log_data [MAXOPS], log_cmp [MAXOPS];
   logic        log_x [MAXOPS], log_s8 [MAXOPS];

   int          exp_n;
   logic [63:0] exp_addr [MAXOPS], exp_data [MAXOPS], exp_cmp [MAXOPS];
   logic        exp_x [MAXOPS], exp_s8 [MAXOPS];
   string       exp_tag [MAXOPS];
   bit          exp_fault, exp_usr_wr, exp_fast;
   string       flt_tag;
   logic [63:0] exp_ssp, exp_usr;

   ssfp_frame_pusher dut (
      .clk(clk), .rst_n(rst_n), .start(start), .more_priv(more_priv),
      .tgt_long(tgt_long), .long_active(long_active), .caller_pl(caller_pl),
      .cur_ssp(cur_ssp), .new_ssp(new_ssp), .old_sel(old_sel), .cs_base(cs_base),
      .old_ip(old_ip), .busy(busy), .done(done), .fault(fault), .ssp_wr(ssp_wr),
      .ssp_out(ssp_out), .usr_wr(usr_wr), .usr_ssp(usr_ssp), .mem_req(mem_req),
      .mem_xchg(mem_xchg), .mem_size8(mem_size8), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_cmp(mem_cmp), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // memory responder: random 0..3 cycle wait, logs each acknowledged request
   initial begin
      int dly;
      dly = -1;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (dly < 0) dly = int'($urandom_range(0, 3));
            if (dly == 0) begin
               if (log_n < MAXOPS) begin
                  log_addr[log_n] = mem_addr;
                  log_data[log_n] = mem_wdata;
                  log_cmp[log_n]  = mem_cmp;
                  log_x[log_n]    = mem_xchg;
                  log_s8[log_n]   = mem_size8;
               end
               log_n++;
               mem_rdata = mem_xchg ? tok_val : 64'h0;
               mem_ack   = 1'b1;
               dly       = -1;
            end else dly--;
         end
      end
   end

   function automatic logic [63:0] uadj(input logic [63:0] x, input bit lma);
      return lma ? {{16{x[47]}}, x[47:0]} : x;
   endfunction

   task automatic add_op(input logic [63:0] a, input logic [63:0] d, input logic [63:0] c,
                         input bit x, input bit s8, input string tag);
      exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_cmp[exp_n] = c;
      exp_x[exp_n] = x; exp_s8[exp_n] = s8; exp_tag[exp_n] = tag;
      exp_n++;
   endtask

   task automatic model(input bit more, input bit tgtl, input bit lma, input logic [1:0] pl,
                        input logic [63:0] cur, input logic [63:0] nw, input logic [15:0] sel,
                        input logic [63:0] lip, input logic [63:0] tok);
      logic [63:0] a, lo;
      exp_n = 0; exp_fault = 0; exp_fast = 0; exp_usr_wr = 0; exp_usr = '0;
      exp_ssp = '0; flt_tag = "R3";
      if (!more) begin
         if (!tgtl && cur[63:32] != 0) begin
            exp_fault = 1; exp_fast = 1; flt_tag = "R4"; return;
         end
         add_op(cur - 64'd4, 64'h0, 64'h0, 0, 0, "R1");
         a = cur & ~64'h7;
         add_op(a - 64'd8,  {48'h0, sel}, 64'h0, 0, 1, "R2");
         add_op(a - 64'd16, lip, 64'h0, 0, 1, "R2");
         add_op(a - 64'd24, cur, 64'h0, 0, 1, "R2");
         exp_ssp = a - 64'd24;
      end else begin
         lo = nw - 64'd24;
         if (nw[2:0] != 0) begin
            exp_fault = 1; exp_fast = 1; flt_tag = "R5"; return;
         end
         if (nw[63:5] != lo[63:5]) begin
            exp_fault = 1; exp_fast = 1; flt_tag = "R6"; return;
         end
         add_op(nw, nw | 64'h1, nw, 1, 1, "R7");
         if (tok != nw) begin
            exp_fault = 1; flt_tag = "R7"; return;
         end
         flt_tag = "R8";
         if (pl != 2'd3) begin
            add_op(nw - 64'd8,  {48'h0, sel}, 64'h0, 0, 1, "R8");
            add_op(nw - 64'd16, lip, 64'h0, 0, 1, "R8");
            add_op(nw - 64'd24, cur, 64'h0, 0, 1, "R8");
            exp_ssp = nw - 64'd24;
         end else begin
            exp_ssp    = nw;
            exp_usr_wr = 1;
            exp_usr    = uadj(cur, lma);
         end
      end
   endtask

   task automatic run_op(input bit more, input bit tgtl, input bit lma, input logic [1:0] pl,
                         input logic [63:0] cur, input logic [63:0] nw, input logic [15:0] sel,
                         input logic [63:0] base, input logic [63:0] ip,
                         input logic [63:0] tok, input bit poke);
      int cyc;
      bit got_done, got_flt, got_swr, got_uwr;
      logic [63:0] got_ssp, got_usr;
      model(more, tgtl, lma, pl, cur, nw, sel, base + ip, tok);
      tok_val = tok;
      log_n = 0;
      more_priv = more; tgt_long = tgtl; long_active = lma; caller_pl = pl;
      cur_ssp = cur; new_ssp = nw; old_sel = sel; cs_base = base; old_ip = ip;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // inputs are captured at start; scramble them to show that (R11)
      cur_ssp = {$urandom, $urandom}; new_ssp = {$urandom, $urandom};
      old_sel = 16'($urandom); cs_base = {$urandom, $urandom}; old_ip = {$urandom, $urandom};
      caller_pl = 2'($urandom); more_priv = ~more;
      cyc = 1;
      forever begin
         if (done || fault) break;
         if (cyc >= 300) break;
         start = poke && (cyc == 2);
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      got_done = done; got_flt = fault; got_swr = ssp_wr; got_uwr = usr_wr;
      got_ssp = ssp_out; got_usr = usr_ssp;
      if (cyc >= 300) begin
         chk(0, flt_tag, "watchdog: no done or fault", 64'(cyc), 64'd0);
         return;
      end
      chk(got_flt == exp_fault && got_done == !exp_fault, flt_tag, "fault outcome",
          64'(got_flt), 64'(exp_fault));
      if (exp_fast)
         chk(cyc == 2, flt_tag, "rule fault latency", 64'(cyc), 64'd2);
      chk(log_n == exp_n, exp_fault ? flt_tag : "R10", "memory op count",
          64'(log_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(log_addr[i] == exp_addr[i], exp_tag[i], "op address", log_addr[i], exp_addr[i]);
         chk(log_data[i] == exp_data[i], exp_tag[i], "op data", log_data[i], exp_data[i]);
         chk(log_x[i] == exp_x[i] && log_s8[i] == exp_s8[i], exp_tag[i], "op kind/size",
             {62'h0, log_x[i], log_s8[i]}, {62'h0, exp_x[i], exp_s8[i]});
         if (exp_x[i])
            chk(log_cmp[i] == exp_cmp[i], "R7", "compare value", log_cmp[i], exp_cmp[i]);
      end
      if (exp_fault) begin
         chk(!got_swr && !got_uwr, "R4", "no update on fault", {62'h0, got_swr, got_uwr}, 64'h0);
      end else begin
         chk(got_swr, "R3", "ssp_wr with done", 64'(got_swr), 64'd1);
         chk(got_ssp == exp_ssp, more ? "R8" : "R3", "final pointer", got_ssp, exp_ssp);
         chk(got_uwr == exp_usr_wr, "R9", "user save strobe", 64'(got_uwr), 64'(exp_usr_wr));
         if (exp_usr_wr)
            chk(got_usr == exp_usr, "R9", "user pointer value", got_usr, exp_usr);
      end
      @(negedge clk);
      chk(!busy && !mem_req && !done && !fault, "R11", "idle after call",
          {60'h0, busy, mem_req, done, fault}, 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog R11: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit mr, tl, lm, bad;
      logic [1:0]  pl;
      logic [63:0] c, n, t;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !mem_req && !done && !fault, "R11", "reset state",
          {60'h0, busy, mem_req, done, fault}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 same level, already aligned, then unaligned
      run_op(0, 0, 0, 2'd0, 64'h1000, 64'h0, 16'h0023, 64'h10000, 64'h44, 64'h0, 0);
      run_op(0, 0, 1, 2'd3, 64'h1004, 64'h0, 16'hbeef, 64'h0, 64'hffff_fff0, 64'h0, 0);
      // R4 high bits, non-64-bit target faults; 64-bit target passes
      run_op(0, 0, 1, 2'd0, 64'h1_0000_2000, 64'h0, 16'h8, 64'h0, 64'h4, 64'h0, 0);
      run_op(0, 1, 1, 2'd0, 64'h1_0000_2006, 64'h0, 16'h8, 64'h0, 64'h4, 64'h0, 0);
      // R5 misaligned target pointer
      run_op(1, 1, 1, 2'd0, 64'h3000, 64'h5ffc, 16'h10, 64'h0, 64'h8, 64'h5ffc, 0);
      // R6 token not at the top slot of its 32-byte region
      run_op(1, 1, 1, 2'd0, 64'h3000, 64'h5ff0, 16'h10, 64'h0, 64'h8, 64'h5ff0, 0);
      // R7 token already busy
      run_op(1, 1, 1, 2'd1, 64'h3000, 64'h5ff8, 16'h10, 64'h0, 64'h8, 64'h5ff9, 0);
      // R8 supervisor caller pushes frame; poke start while busy (R11)
      run_op(1, 1, 1, 2'd0, 64'h3008, 64'h5ff8, 16'h10, 64'h100, 64'h8, 64'h5ff8, 1);
      // R9 user caller, long mode sign adjust, and legacy
      run_op(1, 1, 1, 2'd3, 64'h0000_8000_0000_1230, 64'h7fd8, 16'h33, 64'h0, 64'h8, 64'h7fd8, 0);
      run_op(1, 0, 0, 2'd3, 64'h0000_8000_0000_1230, 64'h7fd8, 16'h33, 64'h0, 64'h8, 64'h7fd8, 0);

      // constrained random mix
      for (int k = 0; k < 60; k++) begin
         mr = 1'($urandom); tl = 1'($urandom); lm = 1'($urandom); pl = 2'($urandom);
         c = {$urandom, $urandom};
         if ($urandom_range(0, 1) == 0) c[63:32] = '0;
         n = {$urandom, $urandom};
         bad = ($urandom_range(0, 4) == 0);
         if (!bad) n[4:0] = 5'h18;
         t = ($urandom_range(0, 4) == 0) ? (n | 64'h1) : n;
         run_op(mr, tl, lm, pl, c, n, 16'($urandom), {$urandom, $urandom},
                {$urandom, $urandom}, t, ($urandom_range(0, 3) == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule